// File: doc/BRIEF.md
# Programmable Wait-State External Memory Controller

This block turns single requests from an internal port into strobe sequences for an asynchronous external memory such as a NOR flash or an SRAM. A request carries a word address, a direction, a burst length of one to four data phases and the write data for every phase. The controller drives the external address, the active-low chip-enable, output-enable and write-enable strobes, and the data pad signals. It returns all read words together with a one-cycle completion pulse.

Every strobe edge is placed by three wait-state counts held in a small configuration register: access (address to first data), beat (data to data inside a read burst) and recovery (idle time after a transfer). The external data bus is split into pad-side signals (`mem_dq_out`, `mem_dq_oe`, `mem_dq_in`), which the chip's pad ring joins into one bidirectional bus.

The sequencer has six named states. IDLE accepts a request (transition to RD_LEAD for a read, to WR_SETUP for a write). RD_LEAD covers the first read phase; at its end the word is sampled and the machine goes to RD_BEAT (more phases) or RECOVER (last phase). RD_BEAT covers each later read phase with the same exits. WR_SETUP holds two cycles with write-enable high and then moves to WR_PULSE. WR_PULSE holds write-enable low and exits to WR_SETUP (more phases) or RECOVER (last phase). RECOVER keeps all strobes high and returns to IDLE when it ends.

Top module: `ext_mem_waitctl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_done` is 0, `mem_dq_oe` is 0 and all three strobes are 1. The timing counts come up as access 4, beat 4, recovery 1.
- R2: A pulse on `cfg_load` while `req_ready` is 1 loads the three counts with clamping: access and beat to 4..20 and recovery to 1..20. A pulse while `req_ready` is 0 is ignored.
- R3: On a read, `mem_oe_n` falls in cycle 1 and `mem_ce_n` in cycle 2, where cycle 0 is the first cycle the address is driven. Both stay low until the last word is sampled. `mem_we_n` stays high.
- R4: A read samples its first word at the end of cycle A+3, where A is the access count. It samples each later word B+2 cycles after the previous one, where B is the beat count. `rsp_done` goes high in the cycle after the last sample, so it appears in cycle A+4+(N-1)(B+2).
- R5: `req_len` encodes the burst as N-1, so 0 means one phase and 3 means four. The external address starts at `req_addr` and increments by one for each phase.
- R6: Each write phase drives the address with `mem_we_n` high for 2 cycles, then drives `mem_we_n` low for A+1 cycles. `mem_ce_n` is low through the whole write burst. `rsp_done` appears in cycle N(A+3).
- R7: `mem_dq_oe` is 1 exactly in the cycles where `mem_we_n` is 0. While it is 1, `mem_dq_out` carries the current phase's write word.
- R8: After the last phase, recovery lasts R cycles for a read and R+1 cycles for a write, where R is the recovery count. During recovery all strobes are high and the address holds its last value.
- R9: `req_ready` is 0 from the cycle after acceptance until recovery ends. `rsp_done` is high for exactly one cycle per request.
- R10: Read word i is returned in `rsp_rdata[i*DW +: DW]`. Write word i is taken from `req_wdata[i*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load the three timing counts |
| cfg_access | input | WS_W | Access count (address to first data) |
| cfg_beat | input | WS_W | Beat count (data to data) |
| cfg_recover | input | WS_W | Recovery count |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address of first phase |
| req_len | input | BEAT_W | Phases minus one |
| req_wdata | input | MAX_BEATS*DW | Packed write words |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | MAX_BEATS*DW | Packed read words |
| mem_addr | output | AW | External address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DW | Data toward the pad |
| mem_dq_oe | output | 1 | Pad output driver enable |
| mem_dq_in | input | DW | Data from the pad |

## Verification
Bursts of one and of four phases are mixed in both directions, so a wrong address increment or a wrong phase count shows up as a wrong word or a wrong completion cycle. Counts at the minimum, at the maximum and outside the legal range are loaded, which separates clamping mistakes from off-by-one errors in the access, beat and recovery terms. Read and write recovery are measured separately to catch the extra write cycle. A configuration pulse sent in the middle of a transfer shows whether the busy guard holds. Random counts, directions and lengths from a fixed seed then cover the combinations between these points.

// File: rtl/ext_mem_waitctl_pkg.sv
package ext_mem_waitctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LEAD,
        ST_RD_BEAT,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_RECOVER
    } seq_state_e;
endpackage

// File: rtl/ext_mem_timing_cfg.sv
module ext_mem_timing_cfg #(
    parameter int WS_W    = 5,
    parameter int ACC_MIN = 4,
    parameter int ACC_MAX = 20,
    parameter int BT_MIN  = 4,
    parameter int BT_MAX  = 20,
    parameter int RC_MIN  = 1,
    parameter int RC_MAX  = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [WS_W-1:0] acc_in,
    input  logic [WS_W-1:0] beat_in,
    input  logic [WS_W-1:0] rec_in,
    output logic [WS_W-1:0] acc_q,
    output logic [WS_W-1:0] beat_q,
    output logic [WS_W-1:0] rec_q
);
    function automatic logic [WS_W-1:0] limit_to(input logic [WS_W-1:0] v,
                                                 input int lo, input int hi);
        if (int'(v) < lo)      return WS_W'(lo);
        else if (int'(v) > hi) return WS_W'(hi);
        else                   return v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= WS_W'(ACC_MIN);
            beat_q <= WS_W'(BT_MIN);
            rec_q  <= WS_W'(RC_MIN);
        end else if (load_en) begin
            acc_q  <= limit_to(acc_in, ACC_MIN, ACC_MAX);
            beat_q <= limit_to(beat_in, BT_MIN, BT_MAX);
            rec_q  <= limit_to(rec_in, RC_MIN, RC_MAX);
        end
    end

    // R2: held counts always within the legal windows
    p_cfg_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_q) >= ACC_MIN) && (int'(acc_q) <= ACC_MAX) &&
        (int'(beat_q) >= BT_MIN) && (int'(beat_q) <= BT_MAX) &&
        (int'(rec_q) >= RC_MIN) && (int'(rec_q) <= RC_MAX));
endmodule

// File: rtl/ext_mem_sequencer.sv
module ext_mem_sequencer
    import ext_mem_waitctl_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int MAX_BEATS = 4,
    parameter int WS_W      = 5,
    parameter int WS_MAX    = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WS_W-1:0]         acc_cnt,
    input  logic [WS_W-1:0]         beat_cnt,
    input  logic [WS_W-1:0]         rec_cnt,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [AW-1:0]           req_addr,
    input  logic [$clog2(MAX_BEATS)-1:0] req_len,
    input  logic [MAX_BEATS*DW-1:0] req_wdata,
    output logic                    rsp_done,
    output logic [MAX_BEATS*DW-1:0] rsp_rdata,
    output logic [AW-1:0]           mem_addr,
    output logic                    mem_ce_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [DW-1:0]           mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [DW-1:0]           mem_dq_in
);
    localparam int BEAT_W = $clog2(MAX_BEATS);
    localparam int CNT_W  = $clog2(WS_MAX + 5);

    seq_state_e             state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, limit;
    logic [BEAT_W-1:0]      beat_q, len_q;
    logic [CNT_W-1:0]       rec_len_q;
    logic [MAX_BEATS*DW-1:0] wdata_q, rdata_q;
    logic [AW-1:0]          addr_q;
    logic                   done_q;
    logic                   phase_end, last_beat;

    assign last_beat = (beat_q == len_q);

    always_comb begin
        unique case (state_q)
            ST_RD_LEAD:  limit = CNT_W'(acc_cnt) + CNT_W'(3);
            ST_RD_BEAT:  limit = CNT_W'(beat_cnt) + CNT_W'(1);
            ST_WR_SETUP: limit = CNT_W'(1);
            ST_WR_PULSE: limit = CNT_W'(acc_cnt);
            ST_RECOVER:  limit = rec_len_q - CNT_W'(1);
            default:     limit = '0;
        endcase
        phase_end = (state_q != ST_IDLE) && (cnt_q == limit);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_LEAD;
            ST_RD_LEAD,
            ST_RD_BEAT:  if (phase_end) state_d = last_beat ? ST_RECOVER : ST_RD_BEAT;
            ST_WR_SETUP: if (phase_end) state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (phase_end) state_d = last_beat ? ST_RECOVER : ST_WR_SETUP;
            ST_RECOVER:  if (phase_end) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            beat_q    <= '0;
            len_q     <= '0;
            rec_len_q <= CNT_W'(1);
            wdata_q   <= '0;
            rdata_q   <= '0;
            addr_q    <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            cnt_q  <= (phase_end || state_q == ST_IDLE) ? '0 : cnt_q + CNT_W'(1);
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                len_q   <= req_len;
                wdata_q <= req_wdata;
                beat_q  <= '0;
            end
            if (phase_end) begin
                if (state_q == ST_RD_LEAD || state_q == ST_RD_BEAT)
                    rdata_q[beat_q*DW +: DW] <= mem_dq_in;
                if (state_q == ST_RD_LEAD || state_q == ST_RD_BEAT || state_q == ST_WR_PULSE) begin
                    if (last_beat) begin
                        done_q    <= 1'b1;
                        rec_len_q <= (state_q == ST_WR_PULSE) ? CNT_W'(rec_cnt) + CNT_W'(1)
                                                              : CNT_W'(rec_cnt);
                    end else begin
                        beat_q <= beat_q + BEAT_W'(1);
                        addr_q <= addr_q + AW'(1);
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_done   = done_q;
        rsp_rdata  = rdata_q;
        mem_addr   = addr_q;
        mem_dq_out = wdata_q[beat_q*DW +: DW];
        mem_ce_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        unique case (state_q)
            ST_RD_LEAD: begin
                mem_oe_n = (cnt_q < CNT_W'(1));
                mem_ce_n = (cnt_q < CNT_W'(2));
            end
            ST_RD_BEAT: begin
                mem_oe_n = 1'b0;
                mem_ce_n = 1'b0;
            end
            ST_WR_SETUP: mem_ce_n = 1'b0;
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    p_dq_drive_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);
    p_we_inside_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);
    p_oe_we_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_addr_hold_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && $past(state_q == ST_RECOVER)) |-> $stable(mem_addr));
    p_recover_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));
endmodule

// File: rtl/ext_mem_waitctl.sv
module ext_mem_waitctl #(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int MAX_BEATS = 4,
    parameter int WS_W      = 5,
    parameter int BEAT_W    = $clog2(MAX_BEATS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic [WS_W-1:0]         cfg_access,
    input  logic [WS_W-1:0]         cfg_beat,
    input  logic [WS_W-1:0]         cfg_recover,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [AW-1:0]           req_addr,
    input  logic [BEAT_W-1:0]       req_len,
    input  logic [MAX_BEATS*DW-1:0] req_wdata,
    output logic                    rsp_done,
    output logic [MAX_BEATS*DW-1:0] rsp_rdata,
    output logic [AW-1:0]           mem_addr,
    output logic                    mem_ce_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [DW-1:0]           mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [DW-1:0]           mem_dq_in
);
    localparam int WS_LIMIT = 20;

    logic [WS_W-1:0] acc_q, beat_q, rec_q;

    ext_mem_timing_cfg #(
        .WS_W(WS_W), .ACC_MIN(4), .ACC_MAX(WS_LIMIT),
        .BT_MIN(4), .BT_MAX(WS_LIMIT), .RC_MIN(1), .RC_MAX(WS_LIMIT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .load_en(cfg_load && req_ready),
        .acc_in(cfg_access), .beat_in(cfg_beat), .rec_in(cfg_recover),
        .acc_q(acc_q), .beat_q(beat_q), .rec_q(rec_q)
    );

    ext_mem_sequencer #(
        .AW(AW), .DW(DW), .MAX_BEATS(MAX_BEATS), .WS_W(WS_W), .WS_MAX(WS_LIMIT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .acc_cnt(acc_q), .beat_cnt(beat_q), .rec_cnt(rec_q),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );
endmodule

// File: tb/tb_ext_mem_waitctl.sv
module tb_ext_mem_waitctl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, DW = 16, NB = 4, WS_W = 5;

    logic clk = 0, rst_n = 0;
    logic cfg_load = 0;
    logic [WS_W-1:0] cfg_access = 0, cfg_beat = 0, cfg_recover = 0;
    logic req_valid = 0, req_write = 0;
    logic req_ready, rsp_done, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] req_addr = 0, mem_addr;
    logic [1:0] req_len = 0;
    logic [NB*DW-1:0] req_wdata = 0, rsp_rdata;
    logic [DW-1:0] mem_dq_out, mem_dq_in;
    logic [DW-1:0] mem [0:255];

    int n_tests = 0, n_fail = 0, cyc_total = 0;
    int a_cur = 4, b_cur = 4, r_cur = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_dq_in = (!mem_oe_n && !mem_ce_n) ? mem[mem_addr[7:0]] : 16'hDEAD;

    ext_mem_waitctl #(.AW(AW), .DW(DW), .MAX_BEATS(NB), .WS_W(WS_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_access(cfg_access),
        .cfg_beat(cfg_beat), .cfg_recover(cfg_recover), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampv(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int done_cycle(input bit wr, input int n, input int a, input int b);
        return wr ? n * (a + 3) : (a + 4 + (n - 1) * (b + 2));
    endfunction

    // R2: load counts (bench tracks clamped values)
    task automatic set_cfg(input int a, input int b, input int r);
        @(negedge clk);
        cfg_access = WS_W'(a); cfg_beat = WS_W'(b); cfg_recover = WS_W'(r);
        cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
        a_cur = clampv(a, 4, 20); b_cur = clampv(b, 4, 20); r_cur = clampv(r, 1, 20);
    endtask

    task automatic run_txn(input bit wr, input int addr, input int n,
                           input logic [NB*DW-1:0] wd, input bit mid_cfg);
        int exp_done, exp_rdy, c;
        int first_oe, first_ce, done_at, done_cnt, rdy_at, ce_low, run, pulses, bad_pulse;
        int oe_mis, rec_bad, ce_low_wr;
        logic [AW-1:0] last_addr;
        exp_done = done_cycle(wr, n, a_cur, b_cur);
        exp_rdy  = exp_done + r_cur + (wr ? 1 : 0);
        last_addr = AW'(addr + n - 1);
        first_oe = -1; first_ce = -1; done_at = -1; done_cnt = 0; rdy_at = -1;
        ce_low = 0; run = 0; pulses = 0; bad_pulse = 0; oe_mis = 0; rec_bad = 0; ce_low_wr = 0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = AW'(addr); req_len = 2'(n - 1); req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        c = 0;
        while (rdy_at < 0 && c < 400) begin
            if (mid_cfg && c == 3) begin cfg_access = 5'd31; cfg_beat = 5'd31; cfg_recover = 5'd31; cfg_load = 1; end
            else cfg_load = 0;
            if (!mem_oe_n && first_oe < 0) first_oe = c;
            if (!mem_ce_n && first_ce < 0) first_ce = c;
            if (!mem_ce_n) ce_low++;
            if (mem_dq_oe != !mem_we_n) oe_mis++;
            if (!mem_we_n) begin
                run++;
                mem[mem_addr[7:0]] = mem_dq_out;
            end else if (run > 0) begin
                pulses++;
                if (run != a_cur + 1) bad_pulse++;
                run = 0;
            end
            if (rsp_done) begin
                done_cnt++;
                if (done_at < 0) done_at = c;
            end
            if (done_at >= 0 && (!mem_ce_n || !mem_oe_n || !mem_we_n || mem_addr != last_addr))
                rec_bad++;
            if (req_ready) rdy_at = c;
            @(posedge clk);
            @(negedge clk);
            c++;
        end
        cfg_load = 0;
        chk(done_at == exp_done, wr ? "R6 done cycle" : "R4 done cycle", done_at, exp_done);
        chk(rdy_at == exp_rdy, "R8/R9 ready return cycle", rdy_at, exp_rdy);
        chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
        chk(oe_mis == 0, "R7 pad enable tracks write enable", oe_mis, 0);
        chk(rec_bad == 0, "R8 recovery quiet and address held", rec_bad, 0);
        if (wr) begin
            chk(pulses == n && bad_pulse == 0, "R6 write pulse count/width", pulses, n);
            chk(first_oe == -1, "R6 no output enable on write", first_oe, -1);
            chk(ce_low == exp_done, "R6 chip enable held over burst", ce_low, exp_done);
            for (int i = 0; i < n; i++)
                chk(mem[8'(addr + i)] == wd[i*DW +: DW], "R5/R10 written word",
                    int'(mem[8'(addr + i)]), int'(wd[i*DW +: DW]));
        end else begin
            chk(first_oe == 1 && first_ce == 2, "R3 strobe fall cycles", first_oe * 10 + first_ce, 12);
            chk(ce_low == exp_done - 2, "R3 strobes held low", ce_low, exp_done - 2);
            for (int i = 0; i < n; i++)
                chk(rsp_rdata[i*DW +: DW] == mem[8'(addr + i)], "R4/R5/R10 read word",
                    int'(rsp_rdata[i*DW +: DW]), int'(mem[8'(addr + i)]));
        end
    endtask

    initial begin
        while (cyc_total < 150000) begin
            @(posedge clk);
            cyc_total++;
        end
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) mem[i] = DW'(i * 16'h0101 + 16'h1357);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_done && !mem_dq_oe && mem_ce_n && mem_oe_n && mem_we_n,
            "R1 reset outputs", int'(req_ready), 1);
        rst_n = 1;
        // R1 default counts 4/4/1 observed through timing
        run_txn(0, 10, 1, '0, 0);
        run_txn(1, 20, 1, 64'h0000_0000_0000_BEEF, 0);
        // R5 four-phase bursts
        run_txn(1, 40, 4, 64'h4444_3333_2222_1111, 0);
        run_txn(0, 40, 4, '0, 0);
        // R2 clamp low and high
        set_cfg(0, 0, 0);
        run_txn(0, 60, 2, '0, 0);
        set_cfg(31, 31, 31);
        run_txn(0, 70, 4, '0, 0);
        run_txn(1, 80, 3, 64'h0000_AAAA_5555_F00F, 0);
        // R2 load ignored while busy
        set_cfg(6, 9, 2);
        run_txn(0, 90, 3, '0, 1);
        run_txn(1, 100, 2, 64'h0000_0000_1234_5678, 0);
        // random mix
        for (int k = 0; k < 40; k++) begin
            if (k % 4 == 0) set_cfg(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                                    int'($urandom_range(0, 31)));
            run_txn(bit'($urandom_range(0, 1)), int'($urandom_range(0, 250)),
                    int'($urandom_range(1, 4)), {$urandom, $urandom}, bit'(k % 7 == 3));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule